// File: doc/BRIEF.md
# Three-Stage Nonblocking Clos Switch with Path Controller

This block is a circuit-switched fabric built from three stages of small full crossbars. It has `R_IN` ingress nodes of `N_IN` ports each and `R_OUT` egress nodes of `P_OUT` ports each. Between them sit `N_IN + P_OUT - 1` middle crossbars, and each middle crossbar has one link to every ingress node and one link to every egress node. Data words pass from an ingress port to an egress port through a single middle crossbar. The data path is combinational and follows the stored crosspoint settings.

A path controller receives one request per cycle. A request either sets up or tears down a route between an input port and an output port. For a set-up it looks for a middle crossbar whose link to the source ingress node and whose link to the destination egress node are both idle. It picks the lowest-numbered such crossbar and writes the crosspoints in all three stages. Routes that already exist are never moved. There are always enough middle crossbars, because a source node can occupy at most `N_IN - 1` of its links and a destination node at most `P_OUT - 1` of its links. Every set-up between two idle ports therefore succeeds.

Top module: `clos_switch`

## Requirements
- R1: While reset is held, and after it is released, `rspValid` is low, every output word is zero, and no route exists.
- R2: Each cycle with `reqValid` high produces exactly one cycle of `rspValid` high at the next clock edge. `rspValid` is low after any cycle without a request.
- R3: A set-up request (`reqDisc`=0) is accepted with `rspOk`=1 whenever both port numbers are in range and both ports are idle, whatever other routes exist.
- R4: An accepted set-up uses the lowest-numbered middle crossbar (0 to `N_IN+P_OUT-2`) whose links to both nodes are idle, and reports it on `rspMid`. Input port i belongs to ingress node i / `N_IN`; output port k belongs to egress node k / `P_OUT`.
- R5: After an accepted set-up from input i to output k, output word k (bits k*W+W-1 : k*W of `dataOut`) equals input word i of `dataIn`. This holds from the clock edge that raises `rspValid`.
- R6: A set-up to an input port or an output port that is already in use is rejected with `rspOk`=0 and `rspMid`=0. The routing does not change.
- R7: A tear-down (`reqDisc`=1) of an existing route reports `rspOk`=1 and the freed middle index on `rspMid`. The output word returns to zero, and the input port and both middle links become available to later set-ups.
- R8: A tear-down naming a pair that is not currently routed is rejected with `rspOk`=0 and changes nothing.
- R9: Existing routes keep carrying their data unchanged while other routes are set up or torn down.
- R10: A request with a port number at or above the port count of its side is rejected with `rspOk`=0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqDisc | input | 1 | 0 = set up route, 1 = tear down route |
| reqIn | input | IN_W ($clog2(R_IN*N_IN+1)) | Input port number |
| reqOut | input | OUT_W ($clog2(R_OUT*P_OUT+1)) | Output port number |
| dataIn | input | R_IN*N_IN*W | Packed input words, word i at bits i*W |
| dataOut | output | R_OUT*P_OUT*W | Packed output words, zero when unrouted |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspOk | output | 1 | Request accepted |
| rspMid | output | MID_W | Middle crossbar used or freed; 0 on rejection |

## Verification
The bench builds the fabric with three ports per edge node, four nodes per side and five middle crossbars, giving twelve ports on each side. This size is large enough for a node to hold two busy links while a set-up arrives, so the selection has to skip past several occupied middle indices. The 4-bit port fields also leave codes 12 to 15 free for out-of-range requests. A long random series of set-ups and tear-downs, checked against an independent occupancy model, tests that no legal set-up is ever refused and that every live route keeps carrying its own input word.

// File: rtl/clos_pkg.sv
package clos_pkg;
  localparam int IDX_W = 8;

  // Update strobes from the path controller to the crosspoint fabric.
  typedef struct packed {
    logic             setEn;
    logic             clrEn;
    logic [IDX_W-1:0] inNode;
    logic [IDX_W-1:0] inLocal;
    logic [IDX_W-1:0] mid;
    logic [IDX_W-1:0] outNode;
    logic [IDX_W-1:0] outLocal;
  } fabric_cmd_t;
endpackage

// File: rtl/clos_mid_pick.sv
module clos_mid_pick #(
  parameter int M     = 5,
  parameter int MID_W = 3
) (
  input  logic [M-1:0]     freeMask,
  output logic             found,
  output logic [MID_W-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int m = M - 1; m >= 0; m--) begin
      if (freeMask[m]) begin
        found = 1'b1;
        pick  = MID_W'(m);
      end
    end
  end
endmodule

// File: rtl/clos_fabric.sv
module clos_fabric
  import clos_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int P_OUT = 3,
  parameter int R_IN  = 4,
  parameter int R_OUT = 4,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fabric_cmd_t              cmd,
  input  logic [R_IN*N_IN*W-1:0]   dataIn,
  output logic [R_OUT*P_OUT*W-1:0] dataOut
);
  localparam int M       = N_IN + P_OUT - 1;
  localparam int TOT_IN  = R_IN * N_IN;
  localparam int TOT_OUT = R_OUT * P_OUT;
  localparam int LIN_W   = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int RIN_W   = (R_IN > 1) ? $clog2(R_IN) : 1;
  localparam int MID_W   = (M > 1) ? $clog2(M) : 1;

  logic [W-1:0] inWord  [TOT_IN];
  logic [W-1:0] outWord [TOT_OUT];
  logic [W-1:0] s1Data  [R_IN][M];
  logic [W-1:0] s2Data  [M][R_OUT];

  logic unusedLocalHi;
  assign unusedLocalHi = |cmd.inLocal;

  for (genvar gk = 0; gk < TOT_IN; gk++) begin : g_unpack
    assign inWord[gk] = dataIn[gk*W +: W];
  end
  for (genvar gk = 0; gk < TOT_OUT; gk++) begin : g_pack
    assign dataOut[gk*W +: W] = outWord[gk];
  end

  // Ingress stage: each node link picks one local input.
  for (genvar gi = 0; gi < R_IN; gi++) begin : g_s1n
    for (genvar gm = 0; gm < M; gm++) begin : g_s1m
      logic             en;
      logic [LIN_W-1:0] sel;
      logic             hit;
      assign hit = (cmd.inNode == IDX_W'(gi)) && (cmd.mid == IDX_W'(gm));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          en  <= 1'b0;
          sel <= '0;
        end else if (cmd.setEn && hit) begin
          en  <= 1'b1;
          sel <= cmd.inLocal[LIN_W-1:0];
        end else if (cmd.clrEn && hit) begin
          en  <= 1'b0;
        end
      end
      assign s1Data[gi][gm] = en ? inWord[gi*N_IN + int'(sel)] : '0;
    end
  end

  // Middle stage: each crossbar output toward an egress node picks an ingress node.
  for (genvar gm = 0; gm < M; gm++) begin : g_s2m
    for (genvar go = 0; go < R_OUT; go++) begin : g_s2o
      logic             en;
      logic [RIN_W-1:0] sel;
      logic             hit;
      assign hit = (cmd.mid == IDX_W'(gm)) && (cmd.outNode == IDX_W'(go));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          en  <= 1'b0;
          sel <= '0;
        end else if (cmd.setEn && hit) begin
          en  <= 1'b1;
          sel <= cmd.inNode[RIN_W-1:0];
        end else if (cmd.clrEn && hit) begin
          en  <= 1'b0;
        end
      end
      assign s2Data[gm][go] = en ? s1Data[sel][gm] : '0;
    end
  end

  // Egress stage: each output port picks a middle link.
  for (genvar go = 0; go < R_OUT; go++) begin : g_s3o
    for (genvar gq = 0; gq < P_OUT; gq++) begin : g_s3q
      logic             en;
      logic [MID_W-1:0] sel;
      logic             hit;
      assign hit = (cmd.outNode == IDX_W'(go)) && (cmd.outLocal == IDX_W'(gq));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          en  <= 1'b0;
          sel <= '0;
        end else if (cmd.setEn && hit) begin
          en  <= 1'b1;
          sel <= cmd.mid[MID_W-1:0];
        end else if (cmd.clrEn && hit) begin
          en  <= 1'b0;
        end
      end
      assign outWord[go*P_OUT + gq] = en ? s2Data[sel][go] : '0;
    end
  end
endmodule

// File: rtl/clos_ctrl.sv
module clos_ctrl
  import clos_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int P_OUT = 3,
  parameter int R_IN  = 4,
  parameter int R_OUT = 4,
  localparam int M       = N_IN + P_OUT - 1,
  localparam int TOT_IN  = R_IN * N_IN,
  localparam int TOT_OUT = R_OUT * P_OUT,
  localparam int IN_W    = $clog2(TOT_IN + 1),
  localparam int OUT_W   = $clog2(TOT_OUT + 1),
  localparam int MID_W   = (M > 1) ? $clog2(M) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqDisc,
  input  logic [IN_W-1:0]  reqIn,
  input  logic [OUT_W-1:0] reqOut,
  output fabric_cmd_t      cmd,
  output logic             rspValid,
  output logic             rspOk,
  output logic [MID_W-1:0] rspMid
);
  logic             inBusy  [TOT_IN];
  logic             outUsed [TOT_OUT];
  logic [IN_W-1:0]  outSrc  [TOT_OUT];
  logic [MID_W-1:0] outMid  [TOT_OUT];
  logic [M-1:0]     inLink  [R_IN];
  logic [M-1:0]     outLink [R_OUT];

  logic             inRange, outRange, connOk, discOk, found;
  logic [MID_W-1:0] pick, useMid;
  logic [M-1:0]     freeMask;
  int               inIdx, outIdx, inNode, outNode;

  always_comb begin
    inRange  = int'(reqIn) < TOT_IN;
    outRange = int'(reqOut) < TOT_OUT;
    inIdx    = inRange ? int'(reqIn) : 0;
    outIdx   = outRange ? int'(reqOut) : 0;
    inNode   = inIdx / N_IN;
    outNode  = outIdx / P_OUT;
    freeMask = ~inLink[inNode] & ~outLink[outNode];
  end

  clos_mid_pick #(.M(M), .MID_W(MID_W)) pick_i (
    .freeMask (freeMask),
    .found    (found),
    .pick     (pick)
  );

  always_comb begin
    connOk = inRange && outRange && !inBusy[inIdx] && !outUsed[outIdx] && found;
    discOk = inRange && outRange && outUsed[outIdx] && (outSrc[outIdx] == reqIn);
    useMid = reqDisc ? outMid[outIdx] : pick;
    cmd          = '0;
    cmd.setEn    = reqValid && !reqDisc && connOk;
    cmd.clrEn    = reqValid && reqDisc && discOk;
    cmd.inNode   = IDX_W'(inNode);
    cmd.inLocal  = IDX_W'(inIdx % N_IN);
    cmd.mid      = IDX_W'(useMid);
    cmd.outNode  = IDX_W'(outNode);
    cmd.outLocal = IDX_W'(outIdx % P_OUT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TOT_IN; i++) inBusy[i] <= 1'b0;
      for (int k = 0; k < TOT_OUT; k++) begin
        outUsed[k] <= 1'b0;
        outSrc[k]  <= '0;
        outMid[k]  <= '0;
      end
      for (int a = 0; a < R_IN; a++) inLink[a] <= '0;
      for (int b = 0; b < R_OUT; b++) outLink[b] <= '0;
      rspValid <= 1'b0;
      rspOk    <= 1'b0;
      rspMid   <= '0;
    end else begin
      rspValid <= reqValid;
      rspOk    <= cmd.setEn || cmd.clrEn;
      rspMid   <= (cmd.setEn || cmd.clrEn) ? useMid : '0;
      if (cmd.setEn) begin
        inBusy[inIdx]          <= 1'b1;
        outUsed[outIdx]        <= 1'b1;
        outSrc[outIdx]         <= reqIn;
        outMid[outIdx]         <= pick;
        inLink[inNode][pick]   <= 1'b1;
        outLink[outNode][pick] <= 1'b1;
      end
      if (cmd.clrEn) begin
        inBusy[inIdx]            <= 1'b0;
        outUsed[outIdx]          <= 1'b0;
        inLink[inNode][useMid]   <= 1'b0;
        outLink[outNode][useMid] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clos_switch.sv
module clos_switch
  import clos_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int P_OUT = 3,
  parameter int R_IN  = 4,
  parameter int R_OUT = 4,
  parameter int W     = 8,
  localparam int M       = N_IN + P_OUT - 1,
  localparam int IN_W    = $clog2(R_IN * N_IN + 1),
  localparam int OUT_W   = $clog2(R_OUT * P_OUT + 1),
  localparam int MID_W   = (M > 1) ? $clog2(M) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqDisc,
  input  logic [IN_W-1:0]          reqIn,
  input  logic [OUT_W-1:0]         reqOut,
  input  logic [R_IN*N_IN*W-1:0]   dataIn,
  output logic [R_OUT*P_OUT*W-1:0] dataOut,
  output logic                     rspValid,
  output logic                     rspOk,
  output logic [MID_W-1:0]         rspMid
);
  fabric_cmd_t cmd;

  clos_ctrl #(.N_IN(N_IN), .P_OUT(P_OUT), .R_IN(R_IN), .R_OUT(R_OUT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqDisc  (reqDisc),
    .reqIn    (reqIn),
    .reqOut   (reqOut),
    .cmd      (cmd),
    .rspValid (rspValid),
    .rspOk    (rspOk),
    .rspMid   (rspMid)
  );

  clos_fabric #(.N_IN(N_IN), .P_OUT(P_OUT), .R_IN(R_IN), .R_OUT(R_OUT), .W(W)) fabric_i (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );
endmodule

// File: rtl/clos_switch_chk.sv
module clos_switch_chk #(
  parameter int MID_N = 5,
  parameter int MID_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             cmdSet,
  input logic             cmdClr,
  input logic             rspValid,
  input logic             rspOk,
  input logic [MID_W-1:0] rspMid
);
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_reject_no_update_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cmdSet && !cmdClr) |=> (!rspOk && rspMid == '0));

  assert_update_reports_ok_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSet || cmdClr) |=> (rspValid && rspOk));

  assert_mid_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOk) |-> (int'(rspMid) < MID_N));

  assert_single_update_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdSet, cmdClr}));
endmodule

bind clos_switch clos_switch_chk #(.MID_N(M), .MID_W(MID_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .cmdSet   (cmd.setEn),
  .cmdClr   (cmd.clrEn),
  .rspValid (rspValid),
  .rspOk    (rspOk),
  .rspMid   (rspMid)
);

// File: tb/clos_switch_tb.sv
module clos_switch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int NR = 4;
  localparam int NM = 2 * NP - 1;
  localparam int NPORT = NP * NR;
  localparam int W = 8;

  typedef struct packed {
    logic       disc;
    logic [3:0] inP;
    logic [3:0] outP;
    logic       ok;
    logic [2:0] mid;
    logic [3:0] req;
  } vec_t;

  // Directed sequence; the last field is the requirement number printed by the check.
  localparam vec_t VEC [15] = '{
    '{1'b0, 4'd0,  4'd0,  1'b1, 3'd0, 4'd3},   // R3 first route
    '{1'b0, 4'd1,  4'd1,  1'b1, 3'd1, 4'd4},   // R4 skip busy mid 0
    '{1'b0, 4'd3,  4'd2,  1'b1, 3'd2, 4'd4},   // R4 egress side busy 0,1
    '{1'b0, 4'd2,  4'd6,  1'b1, 3'd2, 4'd4},   // R4 ingress side busy 0,1
    '{1'b0, 4'd4,  4'd7,  1'b1, 3'd0, 4'd4},   // R4 both sides busy on 2 only
    '{1'b0, 4'd0,  4'd5,  1'b0, 3'd0, 4'd6},   // R6 input port in use
    '{1'b0, 4'd5,  4'd0,  1'b0, 3'd0, 4'd6},   // R6 output port in use
    '{1'b0, 4'd12, 4'd3,  1'b0, 3'd0, 4'd10},  // R10 input out of range
    '{1'b1, 4'd1,  4'd1,  1'b1, 3'd1, 4'd7},   // R7 tear-down frees mid 1
    '{1'b1, 4'd1,  4'd1,  1'b0, 3'd0, 4'd8},   // R8 already torn down
    '{1'b1, 4'd0,  4'd6,  1'b0, 3'd0, 4'd8},   // R8 wrong source
    '{1'b0, 4'd1,  4'd1,  1'b1, 3'd1, 4'd7},   // R7 freed mid reused
    '{1'b0, 4'd6,  4'd3,  1'b1, 3'd0, 4'd3},   // R3 fresh nodes
    '{1'b0, 4'd7,  4'd4,  1'b1, 3'd1, 4'd3},   // R3 second on same nodes
    '{1'b0, 4'd9,  4'd15, 1'b0, 3'd0, 4'd10}   // R10 output out of range
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqDisc = 1'b0;
  logic [3:0] reqIn = '0;
  logic [3:0] reqOut = '0;
  logic [NPORT*W-1:0] dataIn = '0;
  logic [NPORT*W-1:0] dataOut;
  logic rspValid, rspOk;
  logic [2:0] rspMid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int mSrc [NPORT];
  int mMid [NPORT];
  bit mInBusy [NPORT];
  bit linkIn [NR][NM];
  bit linkOut [NR][NM];

  always #(CLK_PERIOD/2) clk = ~clk;

  clos_switch #(.N_IN(NP), .P_OUT(NP), .R_IN(NR), .R_OUT(NR), .W(W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDisc(reqDisc),
    .reqIn(reqIn), .reqOut(reqOut), .dataIn(dataIn), .dataOut(dataOut),
    .rspValid(rspValid), .rspOk(rspOk), .rspMid(rspMid)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int k = 0; k < NPORT; k++) begin
      mSrc[k] = -1; mMid[k] = 0; mInBusy[k] = 1'b0;
    end
    for (int a = 0; a < NR; a++)
      for (int m = 0; m < NM; m++) begin
        linkIn[a][m] = 1'b0; linkOut[a][m] = 1'b0;
      end
  endtask

  task automatic modelStep(bit disc, int inP, int outP, output bit ok, output int mid);
    ok = 1'b0; mid = 0;
    if (inP < NPORT && outP < NPORT) begin
      if (!disc) begin
        if (!mInBusy[inP] && mSrc[outP] < 0) begin
          mid = -1;
          for (int m = 0; m < NM; m++)
            if (mid < 0 && !linkIn[inP/NP][m] && !linkOut[outP/NP][m]) mid = m;
          if (mid >= 0) begin
            ok = 1'b1;
            mSrc[outP] = inP; mMid[outP] = mid; mInBusy[inP] = 1'b1;
            linkIn[inP/NP][mid] = 1'b1; linkOut[outP/NP][mid] = 1'b1;
          end else begin
            mid = 7;  // nonblocking violated: expect ok=1 anyway (R3)
            ok = 1'b1;
          end
        end
      end else if (mSrc[outP] == inP) begin
        ok = 1'b1; mid = mMid[outP];
        mSrc[outP] = -1; mInBusy[inP] = 1'b0;
        linkIn[inP/NP][mid] = 1'b0; linkOut[outP/NP][mid] = 1'b0;
      end
    end
  endtask

  task automatic checkData();
    logic [NPORT*W-1:0] exp;
    exp = '0;
    for (int k = 0; k < NPORT; k++)
      if (mSrc[k] >= 0) exp[k*W +: W] = dataIn[mSrc[k]*W +: W];
    chk("R5/R9 routed words", dataOut, exp);
  endtask

  task automatic doReq(bit disc, int inP, int outP, bit useVec, bit vOk, int vMid, int vReq);
    bit eOk;
    int eMid;
    string tag;
    @(negedge clk);
    reqValid = 1'b1; reqDisc = disc; reqIn = 4'(inP); reqOut = 4'(outP);
    dataIn = {$urandom, $urandom, $urandom};
    modelStep(disc, inP, outP, eOk, eMid);
    if (useVec) begin
      eOk = vOk; eMid = vMid;
      tag = $sformatf("R%0d accept", vReq);
    end else begin
      tag = eOk ? "R3/R7 accept" : "R6/R8/R10 reject";
    end
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 response strobe", rspValid, 1);
    chk(tag, rspOk, eOk);
    chk("R4 middle index", rspMid, eOk ? eMid : 0);
    checkData();
  endtask

  initial begin
    modelClear();
    repeat (2) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1 reset rspValid", rspValid, 0);
    chk("R1 reset dataOut", dataOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset dataOut", dataOut, 0);

    foreach (VEC[v])
      doReq(VEC[v].disc, int'(VEC[v].inP), int'(VEC[v].outP), 1'b1,
            VEC[v].ok, int'(VEC[v].mid), int'(VEC[v].req));

    // Random set-up/tear-down series against the occupancy model (R3, R4, R7, R9)
    for (int it = 0; it < 400; it++) begin
      bit disc;
      int inP, outP;
      disc = ($urandom_range(0, 9) < 4);
      outP = $urandom_range(0, NPORT);
      if (disc && outP < NPORT && mSrc[outP] >= 0 && $urandom_range(0, 3) != 0)
        inP = mSrc[outP];
      else
        inP = $urandom_range(0, NPORT);
      doReq(disc, inP, outP, 1'b0, 1'b0, 0, 0);
      if (it % 4 == 0) begin
        @(negedge clk);
        chk("R2 idle cycle", rspValid, 0);
      end
    end

    // Reset in the middle of traffic clears all routes (R1)
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R1 mid-run reset dataOut", dataOut, 0);
    chk("R1 mid-run reset rspValid", rspValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    modelClear();
    doReq(1'b0, 11, 11, 1'b1, 1'b1, 0, 1);  // R1 table empty: mid 0
    doReq(1'b1, 11, 11, 1'b1, 1'b1, 0, 7);  // R7 tear-down returns zero word

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule